// File: doc/BRIEF.md
# Compare-Driven Multi-Output PWM Submodule

This block is one PWM submodule built around a 16-bit up-counter and six 16-bit compare values. The counter starts at a programmable start value and climbs until it equals compare value 1, which acts as the modulus. On the next clock it returns to the start value. Every compare value has its own equality comparator.

Each of three outputs is a set/reset flip-flop with one comparator for its rising edge and another for its falling edge. Compare value 1 raises the local sync and compare value 0 drops it. The primary PWM output is the inverse of the local sync. Compare values 2 and 3 shape a second output, and compare values 4 and 5 shape a third. Every comparator match also leaves the block as a one-cycle trigger pulse. The matches on compare values 1 and 0 also act as the full-cycle and half-cycle reload pulses.

Software writes go through a simple write port into shadow registers. These are copied into the active compare set only at the full-cycle reload or on force-init. A force-init input presets every output to its configured idle level and restarts the counter at once.

Top module: `pwm_cmp_submod`

## Requirements
- R1: When the active compare value 1 equals `count`, `count` takes the buffered start value on the next clock. Otherwise it increments by one, wrapping from 0xFFFF to 0x0000.
- R2: `full_reload` is high for exactly the one cycle after a cycle in which `count` equals active compare value 1. `half_reload` does the same for active compare value 0.
- R3: `local_sync` goes high in the cycle after a match on compare value 1 and goes low in the cycle after a match on compare value 0. `pwm_x` is always the inverse of `local_sync`.
- R4: `pwm_23` goes high after a match on compare value 2 and low after a match on compare value 3. `pwm_45` goes high after a match on compare value 4 and low after a match on compare value 5.
- R5: When the set match and the clear match of one output occur in the same cycle, the output is low in the following cycle.
- R6: `trig[i]` is high for one cycle, in the cycle after `count` equals active compare value i, for i = 0 to 5.
- R7: A write with `wr_addr` 0 to 5 loads shadow compare value i, and `wr_addr` 6 loads the shadow start value. A write with `wr_addr` 7 is ignored. Shadow values reach the active set only at the clock edge that produces a full reload, or on force-init. The copy takes the shadow content from before a write in that same cycle.
- R8: When `force_init` is high at a clock edge, the following happens at that edge. `pwm_x` takes `init_levels[0]`, `pwm_23` takes `init_levels[1]` and `pwm_45` takes `init_levels[2]`. `count` takes the shadow start value and all shadows are copied to the active set. `trig`, `full_reload` and `half_reload` are low in the next cycle.
- R9: While `rst_n` is low at a clock edge, the following happens. `count` becomes 0 and all compare and start values clear to 0. The outputs take the levels of R8 and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 3 | Shadow register select (0-5 compare, 6 start value) |
| wr_data | input | 16 | Write data |
| init_levels | input | 3 | Idle levels: bit0 pwm_x, bit1 pwm_23, bit2 pwm_45 |
| force_init | input | 1 | Preset outputs and restart counter |
| count | output | 16 | Current counter value |
| local_sync | output | 1 | Local sync signal |
| pwm_x | output | 1 | Inverted local sync output |
| pwm_23 | output | 1 | Output shaped by compare values 2 and 3 |
| pwm_45 | output | 1 | Output shaped by compare values 4 and 5 |
| full_reload | output | 1 | Full-cycle reload pulse |
| half_reload | output | 1 | Half-cycle reload pulse |
| trig | output | 6 | Per-comparator trigger pulses |

## Verification
The bench goes after these corner cases:
- **Equal set and clear values.** A design that lets set win would leave `pwm_23` high instead of low.
- **A modulus write arriving mid-period.** A design without proper buffering would cut the current period short or stretch it.
- **A start value above the modulus.** This forces the counter through its 16-bit wrap. A design that compares with less-than instead of equality would reload early.
- **Force-init in mid-period with new idle levels.** A design that lets pulses through in the forced cycle would emit a stray trigger.
- **Random programming with small moduli.** This catches off-by-one timing on every pulse and output edge.

// File: rtl/pwm_sm_pkg.sv
// Package: shared sizes and the comparator-to-output wiring of the PWM submodule.
// Assumes channel 0 is the local sync (set by compare 1, cleared by compare 0)
// and channel k > 0 is set by compare 2k and cleared by compare 2k+1.
package pwm_sm_pkg;
    localparam int CNT_W   = 16;
    localparam int NUM_CMP = 6;
    localparam int NUM_CH  = NUM_CMP / 2;
    localparam int ADDR_W  = $clog2(NUM_CMP + 2);

    // Comparator index that turns channel k on
    function automatic int set_idx(input int k);
        return (k == 0) ? 1 : 2 * k;
    endfunction

    // Comparator index that turns channel k off
    function automatic int clr_idx(input int k);
        return (k == 0) ? 0 : 2 * k + 1;
    endfunction
endpackage

// File: rtl/pwm_cmp_regs.sv
// Module: shadow and active compare storage.
// Writes land in shadow registers; the active set is refreshed from the
// shadows only when load is high. The shadow start value is read directly by
// the counter, which samples it only at the same load instants.
module pwm_cmp_regs #(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 6,
    parameter int ADDR_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    input  logic                          load,
    output logic [NUM_CMP-1:0][CNT_W-1:0] act_val,
    output logic [CNT_W-1:0]              shd_start
);
    localparam int NUM_SHD = NUM_CMP + 1;

    logic [NUM_SHD-1:0][CNT_W-1:0] shd;

    for (genvar i = 0; i < NUM_SHD; i++) begin : g_shd
        // Capture a software write into shadow register i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shd[i] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                shd[i] <= wr_data;
            end
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_act
        // Copy shadow compare i into the active set on a load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_val[i] <= '0;
            end else if (load) begin
                act_val[i] <= shd[i];
            end
        end
    end

    assign shd_start = shd[NUM_CMP];

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(act_val)) else $error("active compare set changed without a load"); // R7
endmodule

// File: rtl/pwm_cmp_counter.sv
// Module: period counter.
// Counts up by one each clock; on a modulus match or force it loads the start
// value supplied by the register block. Assumes mod_hit is combinational on count.
module pwm_cmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_init,
    input  logic             mod_hit,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    // Advance, restart on modulus, or restart on force
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (force_init || mod_hit) begin
            count <= load_val;
        end else begin
            count <= count + 1'b1;
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (force_init || mod_hit) |=> count == $past(load_val)) else $error("counter did not restart"); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!force_init && !mod_hit) |=> count == CNT_W'($past(count) + 1)) else $error("counter did not step by one"); // R1
endmodule

// File: rtl/pwm_cmp_match.sv
// Module: equality comparators and the one-cycle trigger pulse stage.
// hit is combinational on the current count; trig is hit delayed one clock,
// suppressed in a force cycle. Comparisons are unsigned equality.
module pwm_cmp_match #(
    parameter int CNT_W   = 16,
    parameter int NUM_CMP = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          force_init,
    input  logic [CNT_W-1:0]              count,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] act_val,
    output logic [NUM_CMP-1:0]            hit,
    output logic [NUM_CMP-1:0]            trig
);
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        // Equality compare of comparator i against the counter
        always_comb begin
            hit[i] = (count == act_val[i]);
        end

        // Register the match as a one-cycle trigger pulse
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trig[i] <= 1'b0;
            end else begin
                trig[i] <= hit[i] && !force_init;
            end
        end
    end

    AST_FORCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) force_init |=> trig == '0) else $error("trigger pulse after force"); // R8
endmodule

// File: rtl/pwm_cmp_outff.sv
// Module: one set/reset output flip-flop.
// Force loads the idle level; otherwise clear has priority over set.
// Assumes set_hit and clr_hit come from the comparators of the current cycle.
module pwm_cmp_outff (
    input  logic clk,
    input  logic rst_n,
    input  logic force_init,
    input  logic idle_lvl,
    input  logic set_hit,
    input  logic clr_hit,
    output logic q
);
    // Update the output level from force, clear and set, in that priority
    always_ff @(posedge clk) begin
        if (!rst_n || force_init) begin
            q <= idle_lvl;
        end else if (clr_hit) begin
            q <= 1'b0;
        end else if (set_hit) begin
            q <= 1'b1;
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) (!force_init && clr_hit) |=> !q) else $error("clear match did not drive output low"); // R5
    AST_SET_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (!force_init && set_hit && !clr_hit) |=> q) else $error("set match did not drive output high"); // R4
    AST_FORCE_LVL: assert property (@(posedge clk) disable iff (!rst_n) force_init |=> q == $past(idle_lvl)) else $error("force did not load idle level"); // R8
endmodule

// File: rtl/pwm_cmp_submod.sv
// Module: top of the compare-driven PWM submodule.
// Wires the register block, counter, comparators and one set/reset flip-flop
// per channel. Compare 1 is the modulus and full reload; compare 0 is the
// half reload. Channel 0 holds the local sync, whose inverse is pwm_x.
module pwm_cmp_submod
    import pwm_sm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [NUM_CH-1:0]    init_levels,
    input  logic                 force_init,
    output logic [CNT_W-1:0]     count,
    output logic                 local_sync,
    output logic                 pwm_x,
    output logic                 pwm_23,
    output logic                 pwm_45,
    output logic                 full_reload,
    output logic                 half_reload,
    output logic [NUM_CMP-1:0]   trig
);
    localparam int MOD_IDX  = 1;
    localparam int HALF_IDX = 0;

    logic [NUM_CMP-1:0][CNT_W-1:0] act_val;
    logic [CNT_W-1:0]              shd_start;
    logic [NUM_CMP-1:0]            hit;
    logic [NUM_CH-1:0]             ch_q;
    logic [NUM_CH-1:0]             ch_idle;
    logic                          load;

    // Active set refresh happens at a full reload or a force
    always_comb begin
        load = force_init || hit[MOD_IDX];
    end

    pwm_cmp_regs #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load      (load),
        .act_val   (act_val),
        .shd_start (shd_start)
    );

    pwm_cmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_init (force_init),
        .mod_hit    (hit[MOD_IDX]),
        .load_val   (shd_start),
        .count      (count)
    );

    pwm_cmp_match #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_init (force_init),
        .count      (count),
        .act_val    (act_val),
        .hit        (hit),
        .trig       (trig)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int SI = set_idx(k);
        localparam int CI = clr_idx(k);

        // Idle level per channel; channel 0 stores the sync, which is pwm_x inverted
        always_comb begin
            ch_idle[k] = (k == 0) ? !init_levels[k] : init_levels[k];
        end

        pwm_cmp_outff u_ff (
            .clk        (clk),
            .rst_n      (rst_n),
            .force_init (force_init),
            .idle_lvl   (ch_idle[k]),
            .set_hit    (hit[SI]),
            .clr_hit    (hit[CI]),
            .q          (ch_q[k])
        );
    end

    // Drive the named outputs from the channel flip-flops and pulse stage
    always_comb begin
        local_sync  = ch_q[0];
        pwm_x       = !ch_q[0];
        pwm_23      = ch_q[1];
        pwm_45      = ch_q[2];
        full_reload = trig[MOD_IDX];
        half_reload = trig[HALF_IDX];
    end

    AST_FULL_AFTER_MOD: assert property (@(posedge clk) disable iff (!rst_n) (!force_init && count == act_val[MOD_IDX]) |=> full_reload) else $error("missing full reload pulse"); // R2
    AST_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n) (!force_init && hit[MOD_IDX] && !hit[HALF_IDX]) |=> local_sync && !pwm_x) else $error("local sync did not rise"); // R3
endmodule

// File: tb/test_pwm_cmp_submod.sv
`timescale 1ns/1ps
module test_pwm_cmp_submod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  init_levels = 3'b101;
    logic        force_init = 1'b0;
    logic [15:0] count;
    logic        local_sync, pwm_x, pwm_23, pwm_45, full_reload, half_reload;
    logic [5:0]  trig;

    always #10 clk = ~clk;

    pwm_cmp_submod i_pwm_cmp_submod (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .init_levels(init_levels), .force_init(force_init), .count(count),
        .local_sync(local_sync), .pwm_x(pwm_x), .pwm_23(pwm_23), .pwm_45(pwm_45),
        .full_reload(full_reload), .half_reload(half_reload), .trig(trig)
    );

    int checks = 0;
    int fails = 0;
    bit chk_on = 0;
    bit done = 0;
    string tag = "R9";

    // Behavioural reference state
    int m_shd[7];
    int m_act[6];
    int m_cnt;
    bit m_ls, m_p23, m_p45, m_full, m_half;
    bit m_trig[6];
    bit h[6];

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model step at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_shd[i]) m_shd[i] = 0;
            foreach (m_act[i]) m_act[i] = 0;
            m_cnt = 0;
            m_ls = !init_levels[0]; m_p23 = init_levels[1]; m_p45 = init_levels[2];
            m_full = 0; m_half = 0;
            foreach (m_trig[i]) m_trig[i] = 0;
        end else begin
            foreach (h[i]) h[i] = (m_cnt == m_act[i]);
            if (force_init) begin
                m_ls = !init_levels[0]; m_p23 = init_levels[1]; m_p45 = init_levels[2];
                foreach (m_trig[i]) m_trig[i] = 0;
                m_cnt = m_shd[6];
                foreach (m_act[i]) m_act[i] = m_shd[i];
            end else begin
                foreach (m_trig[i]) m_trig[i] = h[i];
                if (h[0]) m_ls = 0; else if (h[1]) m_ls = 1;
                if (h[3]) m_p23 = 0; else if (h[2]) m_p23 = 1;
                if (h[5]) m_p45 = 0; else if (h[4]) m_p45 = 1;
                if (h[1]) begin
                    m_cnt = m_shd[6];
                    foreach (m_act[i]) m_act[i] = m_shd[i];
                end else begin
                    m_cnt = (m_cnt + 1) & 16'hFFFF;
                end
            end
            m_full = m_trig[1];
            m_half = m_trig[0];
            if (wr_en && wr_addr < 3'd7) m_shd[wr_addr] = int'(wr_data);
        end
    end

    // Compare every output against the model between edges
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check({"R1 ", tag}, "count", int'(count), m_cnt);
            check({"R2 ", tag}, "full_reload", int'(full_reload), int'(m_full));
            check({"R2 ", tag}, "half_reload", int'(half_reload), int'(m_half));
            check({"R3 ", tag}, "local_sync", int'(local_sync), int'(m_ls));
            check({"R3 ", tag}, "pwm_x", int'(pwm_x), int'(!m_ls));
            check({"R4 R5 ", tag}, "pwm_23", int'(pwm_23), int'(m_p23));
            check({"R4 R5 ", tag}, "pwm_45", int'(pwm_45), int'(m_p45));
            for (int i = 0; i < 6; i++)
                check({"R6 ", tag}, $sformatf("trig[%0d]", i), int'(trig[i]), int'(m_trig[i]));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frc();
        @(negedge clk);
        force_init = 1'b1;
        @(negedge clk);
        force_init = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk_on = 1;
        check("R9", "reset count", int'(count), 0);
        check("R9", "reset pwm_x", int'(pwm_x), 1);
        check("R9", "reset pwm_23", int'(pwm_23), 0);
        check("R9", "reset pwm_45", int'(pwm_45), 1);
        check("R9", "reset trig", int'(trig), 0);
        rst_n = 1'b1;

        // R3: centred sync, start 10, modulus 29, half point 19
        tag = "R3";
        wr(6, 10); wr(1, 29); wr(0, 19); wr(2, 12); wr(3, 20); wr(4, 25); wr(5, 14);
        frc();
        idle(80);

        // R7: modulus changed mid-period takes effect only after the reload
        tag = "R7";
        idle(5);
        wr(1, 40);
        idle(20);
        wr(7, 16'h0003);
        idle(80);

        // R5: equal set and clear values keep pwm_23 low
        tag = "R5";
        wr(2, 15); wr(3, 15);
        idle(70);
        check("R5", "pwm_23 equal set/clear", int'(pwm_23), 0);

        // R8: force mid-period with new idle levels
        tag = "R8";
        init_levels = 3'b010;
        idle(7);
        frc();
        idle(40);

        // R1: start above modulus forces the 16-bit wrap
        tag = "R1";
        wr(6, 16'hFFF0); wr(1, 5); wr(0, 16'hFFF8); wr(3, 2); wr(2, 16'hFFFE);
        frc();
        idle(80);

        // R6: random programming with small moduli
        tag = "R6";
        for (int n = 0; n < 300; n++) begin
            wr(int'($urandom_range(0, 7)), int'($urandom_range(0, 40)));
            if ($urandom_range(0, 15) == 0) begin
                init_levels = 3'($urandom_range(0, 7));
                frc();
            end
            idle(int'($urandom_range(0, 12)));
        end
        idle(60);
        finish_run();
    end
endmodule